// File: doc/BRIEF.md
# Table-Row Key Candidate Filter

This block narrows the possible values of one key byte of a block cipher. The evidence is a single row of a byte-wide lookup table held in memory whose rows are a fixed number of bytes wide. A misalignment offset may shift the table's first entry into the middle of a memory row. Before the filter runs, every plaintext byte value was sent once. For each one an intensity maximum was recorded in the time window where the target key byte is looked up. Each maximum tells whether the monitored row was touched.

After a start request the block latches its configuration. It then takes the intensity maxima in plaintext order and turns each into one bit of a measured access set. Next it checks that the monitored row lies inside the span of the table. Finally it tests every key guess in turn. A guess survives only if its predicted access set is exactly the measured set. The result is a mask of surviving guesses and their count, both held until the next start, and a one-cycle completion pulse.

The controller moves through five named states. IDLE waits for `start_i`. LOAD collects samples. VET checks the row. SCAN tests the key guesses. FIN raises the completion pulse. The transitions are:
- IDLE to LOAD on start.
- LOAD to VET when the last sample is accepted.
- VET to SCAN when the row is in range.
- VET to FIN when the row is out of range.
- SCAN to FIN after the last guess.
- FIN to IDLE unconditionally.

Top module: `kcf_filter`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `cfg_err_o` are 0, and `mask_o` and `count_o` are all zeros.
- R2: A sample marks its plaintext as an access only when it is strictly greater than the latched threshold. A sample equal to the threshold marks no access. A cycle with `smp_valid_i` low is skipped, and the next valid sample still takes the next plaintext index.
- R3: The row predicted for plaintext p under guess g is ((p XOR g) + offset) >> log2width, plus 1. Row numbering starts at 1.
- R4: Bit g of `mask_o` is 1 exactly when, for every plaintext p, "predicted row equals the monitored row" has the same value as the measured access bit of p.
- R5: When `done_o` is high, `count_o` equals the number of ones in `mask_o`.
- R6: With 8-byte rows, an odd offset and a valid row, exactly one guess survives, and it is the true key.
- R7: With 8-byte rows and a valid row, offset 0 leaves 8 guesses, and offsets 2 and 6 leave 2 guesses.
- R8: The valid rows are 1 through ((N-1+offset) >> log2width) + 1. For a 256-entry table with 8-byte rows, that is 33 rows at a nonzero offset and 32 at offset 0. Any other row index sets `cfg_err_o` and gives an all-zero mask and a zero count.
- R9: `done_o` is high for exactly one cycle per run. `mask_o`, `count_o` and `cfg_err_o` then hold their values until the next accepted start.
- R10: While `busy_o` is high, `start_i` is ignored, and so are changes to offset, width, row and threshold. The run completes with the configuration latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; only accepted in IDLE |
| offset_i | input | VAL_W | Byte offset of the table start within a memory row |
| log_w_i | input | LW_W | log2 of the memory row width in bytes |
| row_i | input | VAL_W+1 | Monitored row index, first row is 1 |
| thresh_i | input | INT_W | Access threshold |
| smp_valid_i | input | 1 | Intensity sample valid |
| smp_i | input | INT_W | Intensity maximum for the next plaintext |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Monitored row out of the table span |
| mask_o | output | 2**VAL_W | Surviving key guesses, bit g for guess g |
| count_o | output | VAL_W+1 | Number of surviving guesses |

## Verification
The assertions assume a few things about the inputs. Samples arrive only after a start has been accepted. The offset is smaller than the row width. The width exponent leaves at least one row. The stimulus meets these by always pulsing start first and by sweeping offsets only from 0 to width-1 for widths of 4 and 8 bytes. The sweep uses a 32-entry table, where a full run takes about a thousand cycles. Inside that sweep, the true key is varied with the row. Valid gaps, a threshold-equal sample and a start pulse in mid-run are all inserted on purpose, so the hold properties are exercised and not just left unused.

// File: rtl/kcf_pkg.sv
package kcf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_VET,
        ST_SCAN,
        ST_FIN
    } kcf_state_e;

endpackage

// File: rtl/kcf_row_map.sv
// Maps a table index to its 1-based memory row for a power-of-two row width.
module kcf_row_map #(
    parameter int VAL_W = 8,
    parameter int LW_W  = 3,
    localparam int ROW_W = VAL_W + 1
) (
    input  logic [VAL_W-1:0] idx_i,
    input  logic [VAL_W-1:0] off_i,
    input  logic [LW_W-1:0]  lw_i,
    output logic [ROW_W-1:0] row_o
);

    logic [ROW_W-1:0] pos;

    always_comb begin
        pos   = {1'b0, idx_i} + {1'b0, off_i};
        row_o = (pos >> lw_i) + 1'b1;
    end

endmodule

// File: rtl/kcf_sample_cap.sv
// Turns a stream of intensity maxima into a measured access bit per plaintext.
module kcf_sample_cap #(
    parameter int VAL_W = 8,
    parameter int INT_W = 12,
    localparam int N = 1 << VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             vld_i,
    input  logic [INT_W-1:0] smp_i,
    input  logic [INT_W-1:0] thr_i,
    output logic [N-1:0]     meas_o,
    output logic             last_o
);

    logic [VAL_W-1:0] idx_q;
    logic             take;

    assign take   = en_i && vld_i;
    assign last_o = take && (idx_q == {VAL_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            meas_o <= '0;
        end else if (clr_i) begin
            idx_q  <= '0;
        end else if (take) begin
            meas_o[idx_q] <= (smp_i > thr_i);
            idx_q         <= idx_q + 1'b1;
        end
    end

    // R2
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !vld_i && !clr_i) |=> $stable(meas_o));

endmodule

// File: rtl/kcf_key_scan.sv
// Tests one key guess per pass, stopping a pass at the first disagreement.
module kcf_key_scan #(
    parameter int VAL_W = 8,
    parameter int LW_W  = 3,
    localparam int N     = 1 << VAL_W,
    localparam int ROW_W = VAL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             go_i,
    input  logic [N-1:0]     meas_i,
    input  logic [VAL_W-1:0] off_i,
    input  logic [LW_W-1:0]  lw_i,
    input  logic [ROW_W-1:0] row_i,
    output logic [N-1:0]     mask_o,
    output logic [ROW_W-1:0] cnt_o,
    output logic             fin_o
);

    logic [VAL_W-1:0] key_q;
    logic [VAL_W-1:0] pt_q;
    logic [ROW_W-1:0] pred_row;
    logic             hit;
    logic             agree;
    logic             pt_end;
    logic             step_key;

    kcf_row_map #(.VAL_W(VAL_W), .LW_W(LW_W)) u_map (
        .idx_i (pt_q ^ key_q),
        .off_i (off_i),
        .lw_i  (lw_i),
        .row_o (pred_row)
    );

    always_comb begin
        hit      = (pred_row == row_i);
        agree    = (hit == meas_i[pt_q]);
        pt_end   = (pt_q == {VAL_W{1'b1}});
        step_key = !agree || pt_end;
        fin_o    = go_i && step_key && (key_q == {VAL_W{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            pt_q   <= '0;
            mask_o <= '0;
            cnt_o  <= '0;
        end else if (clr_i) begin
            key_q  <= '0;
            pt_q   <= '0;
            mask_o <= '0;
            cnt_o  <= '0;
        end else if (go_i) begin
            if (agree && pt_end) begin
                mask_o[key_q] <= 1'b1;
                cnt_o         <= cnt_o + 1'b1;
            end
            if (step_key) begin
                pt_q  <= '0;
                key_q <= key_q + 1'b1;
            end else begin
                pt_q  <= pt_q + 1'b1;
            end
        end
    end

    // R4
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !clr_i && (hit != meas_i[pt_q])) |=> !mask_o[$past(key_q)]);

endmodule

// File: rtl/kcf_filter.sv
// Key candidate filter: capture, range vetting and exhaustive guess scan.
module kcf_filter
    import kcf_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int INT_W = 12,
    parameter int LW_W  = 3,
    localparam int N     = 1 << VAL_W,
    localparam int ROW_W = VAL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VAL_W-1:0] offset_i,
    input  logic [LW_W-1:0]  log_w_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [INT_W-1:0] thresh_i,
    input  logic             smp_valid_i,
    input  logic [INT_W-1:0] smp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cfg_err_o,
    output logic [N-1:0]     mask_o,
    output logic [ROW_W-1:0] count_o
);

    kcf_state_e state_q, state_d;

    logic [VAL_W-1:0] off_q;
    logic [LW_W-1:0]  lw_q;
    logic [ROW_W-1:0] row_q;
    logic [INT_W-1:0] thr_q;
    logic             err_q;
    logic             accept;
    logic             cap_last;
    logic [N-1:0]     meas;
    logic             scan_fin;
    logic [ROW_W-1:0] last_row;
    logic             row_ok;

    assign accept = (state_q == ST_IDLE) && start_i;

    kcf_sample_cap #(.VAL_W(VAL_W), .INT_W(INT_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .en_i   (state_q == ST_LOAD),
        .vld_i  (smp_valid_i),
        .smp_i  (smp_i),
        .thr_i  (thr_q),
        .meas_o (meas),
        .last_o (cap_last)
    );

    kcf_row_map #(.VAL_W(VAL_W), .LW_W(LW_W)) u_span (
        .idx_i ({VAL_W{1'b1}}),
        .off_i (off_q),
        .lw_i  (lw_q),
        .row_o (last_row)
    );

    assign row_ok = (row_q != '0) && (row_q <= last_row);

    kcf_key_scan #(.VAL_W(VAL_W), .LW_W(LW_W)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .go_i   (state_q == ST_SCAN),
        .meas_i (meas),
        .off_i  (off_q),
        .lw_i   (lw_q),
        .row_i  (row_q),
        .mask_o (mask_o),
        .cnt_o  (count_o),
        .fin_o  (scan_fin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_LOAD;
            ST_LOAD: if (cap_last) state_d = ST_VET;
            ST_VET:  state_d = row_ok ? ST_SCAN : ST_FIN;
            ST_SCAN: if (scan_fin) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // configuration and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            lw_q  <= '0;
            row_q <= '0;
            thr_q <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            off_q <= offset_i;
            lw_q  <= log_w_i;
            row_q <= row_i;
            thr_q <= thresh_i;
            err_q <= 1'b0;
        end else if (state_q == ST_VET) begin
            err_q <= !row_ok;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FIN);
        cfg_err_o = err_q;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(mask_o) && $stable(count_o) && $stable(cfg_err_o)));

    // R5
    count_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == ROW_W'($countones(mask_o))));

    // R8
    err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cfg_err_o) |-> ((mask_o == '0) && (count_o == '0)));

endmodule

// File: tb/sim_kcf_filter.sv
module sim_kcf_filter;

    localparam int VW = 5;
    localparam int N  = 1 << VW;
    localparam int IW = 8;
    localparam int LWW = 3;
    localparam int THR = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [VW-1:0] off = '0;
    logic [LWW-1:0] lw = '0;
    logic [VW:0]   row = '0;
    logic [IW-1:0] thr = '0;
    logic          vld = 1'b0;
    logic [IW-1:0] smp = '0;
    logic          busy, done, err;
    logic [N-1:0]  mask;
    logic [VW:0]   cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    kcf_filter #(.VAL_W(VW), .INT_W(IW), .LW_W(LWW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .offset_i(off),
        .log_w_i(lw), .row_i(row), .thresh_i(thr), .smp_valid_i(vld),
        .smp_i(smp), .busy_o(busy), .done_o(done), .cfg_err_o(err),
        .mask_o(mask), .count_o(cnt)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pred(int v, int o, int l);
        return ((v + o) >> l) + 1;
    endfunction

    // mode 0: spread intensities, mode 1: threshold boundary values
    task automatic run_case(input int o, input int l, input int r, input int key,
                            input int mode, input bit inject);
        logic [N-1:0] acc;
        logic [N-1:0] exp_mask;
        int exp_cnt, last, wait_n;
        bit bad;
        logic [N-1:0] held_mask;
        for (int p = 0; p < N; p++) acc[p] = (pred(p ^ key, o, l) == r);
        last = ((N - 1 + o) >> l) + 1;
        bad = (r < 1) || (r > last);
        exp_mask = '0;
        exp_cnt = 0;
        if (!bad) begin
            for (int g = 0; g < N; g++) begin
                bit ok = 1;
                for (int p = 0; p < N; p++)
                    if ((pred(p ^ g, o, l) == r) != acc[p]) ok = 0;
                if (ok) begin
                    exp_mask[g] = 1'b1;
                    exp_cnt++;
                end
            end
        end
        @(negedge clk);
        off = VW'(o); lw = LWW'(l); row = (VW+1)'(r); thr = IW'(THR); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (p % 5 == 2) begin
                vld = 1'b0; smp = 8'hff;
                @(negedge clk);
            end
            vld = 1'b1;
            if (mode == 1) smp = acc[p] ? IW'(THR + 1) : IW'(THR);
            else           smp = acc[p] ? IW'(THR + 1 + (p * 7) % 50) : IW'((p * 13) % 101);
            if (inject && p == 10) begin
                start = 1'b1; off = '0; row = 1; thr = 8'd0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        vld = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 4000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done == 1'b1, "R9 done", done, 1);
        chk(err == bad, "R8 cfg_err", err, bad);
        chk(mask == exp_mask, inject ? "R10 mask" : "R3 R4 mask", mask, exp_mask);
        chk(int'(cnt) == exp_cnt, "R5 count", cnt, exp_cnt);
        if (bad) chk(mask == '0 && cnt == 0, "R8 blank", mask, 0);
        if (mode == 1) chk(mask[key] == 1'b1, "R2 threshold strict", mask[key], 1);
        if (!bad && l == 3 && (o % 2) == 1)
            chk(cnt == 1 && mask == (N'(1) << key), "R6 unique", mask, N'(1) << key);
        if (!bad && l == 3 && o == 0) chk(cnt == 8, "R7 offset0", cnt, 8);
        if (!bad && l == 3 && (o == 2 || o == 6)) chk(cnt == 2, "R7 offset2/6", cnt, 2);
        held_mask = mask;
        @(negedge clk);
        chk(done == 1'b0, "R9 pulse", done, 0);
        chk(mask == held_mask, "R9 hold", mask, held_mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(done == 0 && busy == 0 && err == 0, "R1 flags", {done, busy, err}, 0);
        chk(mask == '0 && cnt == '0, "R1 results", mask, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R6 R7 sweep over widths 4 and 8, every offset and row
        for (int l = 2; l <= 3; l++)
            for (int o = 0; o < (1 << l); o++) begin
                int last = ((N - 1 + o) >> l) + 1;
                for (int r = 1; r <= last; r++)
                    run_case(o, l, r, (o * 7 + r * 5 + 3) % N, 0, 0);
            end
        // R8 out-of-range rows
        run_case(3, 3, 0, 4, 0, 0);
        run_case(3, 3, 6, 4, 0, 0);
        run_case(0, 3, 5, 4, 0, 0);
        run_case(3, 3, 5, 21, 0, 0);
        // R2 threshold boundary
        run_case(5, 3, 3, 17, 1, 0);
        run_case(1, 2, 4, 6, 1, 0);
        // R10 start and configuration change while busy
        run_case(5, 3, 3, 9, 0, 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule